// File: doc/BRIEF.md
# Dual-Group Parallel I/O Controller with Edge Interrupt

This peripheral provides 48 general-purpose digital lines on a byte-wide synchronous register bus. The lines form two identical groups. Each group holds three 8-bit ports, called A, B and C, and one mode register. The mode register sets the direction of ports A and B as whole bytes. It sets the direction of port C separately for its upper and lower 4-bit halves. A line set as an output drives its latch value and asserts its drive enable. A line set as an input releases its pin. Port reads always return the synchronized pin levels.

Port C bit 3 of each group can raise a rising-edge interrupt. Interrupt control uses the access itself and ignores the data. A write to the enable address turns detection on, and a read of that same address turns it off. A write to the clear address drops any pending request.

The bus has one address, a write strobe, a read strobe and a data byte in each direction. Read data is registered and appears one cycle after the read strobe.

Top module: `pio_dual_group`

## Requirements
- R1: After reset every line is an output (`pin_oe` all ones) driving 0, `irq` is low, interrupts are disabled, and both mode registers read back as 0x80.
- R2: A write to a port offset loads that port's output latch, and `pin_out` shows it from the next cycle. The latch loads whatever the port's direction. Group 0 ports A, B and C are at offsets 0, 1 and 2. Group 1 ports A, B and C are at offsets 4, 5 and 6.
- R3: A write with bit 7 set to a mode offset (3 for group 0, 7 for group 1) stores the byte and sets that group's directions. Bit 4 = 1 makes port A an input, bit 1 = 1 makes port B an input, bit 3 = 1 makes port C bits 7..4 inputs, and bit 0 = 1 makes port C bits 3..0 inputs. An input line has `pin_oe` = 0.
- R4: Every mode-set command clears all three output latches of its own group. It leaves the other group untouched.
- R5: A write to a mode offset with bit 7 clear has no effect on directions, latches or the stored mode byte.
- R6: A read of a port offset returns that port's pin levels after a two-flop synchronizer, whatever the port's direction. A read of a mode offset returns the stored mode byte.
- R7: A read of offsets 8 to 15 returns 0.
- R8: A write of any value to offset 0xB enables interrupt detection.
- R9: A read of offset 0xB disables detection. A request that is already pending stays pending.
- R10: While detection is enabled, a rising edge on line 19 (group 0, port C bit 3) or line 43 (group 1, port C bit 3) sets a sticky pending flag. Falling edges, edges on other lines, and edges while disabled set nothing. `irq` is high while any flag is pending.
- R11: A write of any value to offset 0xF clears both pending flags and drops `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| pin_in | input | 48 | Pin levels seen at the pads |
| pin_out | output | 48 | Output latch values |
| pin_oe | output | 48 | Per-line drive enable, high for outputs |
| irq | output | 1 | Interrupt request, held until cleared |

## Verification
The bench builds the block with its default parameters: two groups of three 8-bit ports, a 4-bit address, a two-stage synchronizer and port C bit 3 as the interrupt source. With these values both groups, both port C halves, the unmapped upper half of the window, and the enable and clear addresses at 0xB and 0xF can all be reached. Random traffic covers every offset with random data and toggles lines 19 and 43 at random. This drives mode and plain control writes, enables and disables, and clears against a model that tracks directions, latches, synchronized pins and pending flags.

// File: rtl/pio_pkg.sv
package pio_pkg;

  // mode word field positions; the bus master encodes these
  localparam int MODE_SET_BIT = 7;
  localparam int A_IN_BIT     = 4;
  localparam int C_HI_IN_BIT  = 3;
  localparam int B_IN_BIT     = 1;
  localparam int C_LO_IN_BIT  = 0;

  typedef struct packed {
    logic a_in;
    logic b_in;
    logic c_hi_in;
    logic c_lo_in;
  } dir_t;

  function automatic dir_t decode_mode(input logic [7:0] m);
    dir_t d;
    d.a_in    = m[A_IN_BIT];
    d.b_in    = m[B_IN_BIT];
    d.c_hi_in = m[C_HI_IN_BIT];
    d.c_lo_in = m[C_LO_IN_BIT];
    return d;
  endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W      = 48,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pio_group.sv
module pio_group
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2:0]     port_wr,
  input  logic           ctrl_wr,
  input  logic [W-1:0]   wdata,
  output logic [3*W-1:0] lat_q,
  output logic [3*W-1:0] oe_q,
  output logic [W-1:0]   mode_q
);

  localparam int H = W / 2;
  localparam logic [W-1:0] MODE_RESET = W'(1) << MODE_SET_BIT;

  dir_t          dir_n;
  logic [3*W-1:0] oe_n;
  logic           mode_cmd;

  assign mode_cmd = ctrl_wr && wdata[MODE_SET_BIT];
  assign dir_n    = decode_mode(wdata[7:0]);

  always_comb begin
    oe_n[0*W +: W] = {W{~dir_n.a_in}};
    oe_n[1*W +: W] = {W{~dir_n.b_in}};
    oe_n[2*W +: H] = {H{~dir_n.c_lo_in}};
    oe_n[2*W+H +: (W-H)] = {(W-H){~dir_n.c_hi_in}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q  <= '0;
      oe_q   <= '1;
      mode_q <= MODE_RESET;
    end else if (mode_cmd) begin
      lat_q  <= '0;
      oe_q   <= oe_n;
      mode_q <= wdata;
    end else begin
      for (int p = 0; p < 3; p++)
        if (port_wr[p]) lat_q[p*W +: W] <= wdata;
    end
  end

  a_r4_mode_clears_latches: assert property (@(posedge clk) disable iff (rst)
    mode_cmd |=> (lat_q == '0));

  a_r5_plain_ctrl_ignored: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !wdata[MODE_SET_BIT]) |=> ($stable(mode_q) && $stable(oe_q) && $stable(lat_q)));

endmodule

// File: rtl/pio_irq.sv
module pio_irq #(
  parameter int G = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_set,
  input  logic         en_clr,
  input  logic         pend_clr,
  input  logic [G-1:0] src,
  output logic         irq
);

  logic         en_q;
  logic [G-1:0] prev_q;
  logic [G-1:0] pend_q;
  logic [G-1:0] rise;
  logic [G-1:0] pend_n;

  assign rise   = src & ~prev_q;
  // a new edge in the clearing cycle is kept
  assign pend_n = (pend_q & ~{G{pend_clr}}) | (rise & {G{en_q}});

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      prev_q <= '0;
      pend_q <= '0;
      irq    <= 1'b0;
    end else begin
      prev_q <= src;
      pend_q <= pend_n;
      irq    <= |pend_n;
      if (en_set)      en_q <= 1'b1;
      else if (en_clr) en_q <= 1'b0;
    end
  end

  a_r8_enable_on_write: assert property (@(posedge clk) disable iff (rst)
    en_set |=> en_q);

  a_r9_disable_on_read: assert property (@(posedge clk) disable iff (rst)
    (en_clr && !en_set) |=> !en_q);

  a_r9_pending_held: assert property (@(posedge clk) disable iff (rst)
    ((pend_q != '0) && !pend_clr) |=> irq);

  a_r10_no_set_disabled: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> ((pend_q & ~$past(pend_q)) == '0));

  a_r11_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (pend_clr && !en_q) |=> (!irq && pend_q == '0));

endmodule

// File: rtl/pio_dual_group.sv
module pio_dual_group
  import pio_pkg::*;
#(
  parameter int GROUPS       = 2,
  parameter int W            = 8,
  parameter int ADDR_W       = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int IRQ_BIT      = 3,
  parameter int IRQ_EN_ADDR  = 11,
  parameter int IRQ_CLR_ADDR = 15,
  localparam int N           = GROUPS * 3 * W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe,
  output logic              irq
);

  localparam int GRP_W = ADDR_W - 2;
  localparam int GW    = 3 * W;

  logic [GRP_W-1:0]  a_grp;
  logic [1:0]        a_sub;
  logic [N-1:0]      pin_s;
  logic [W-1:0]      mode_q [GROUPS];
  logic [GROUPS-1:0] irq_src;
  logic [W-1:0]      rd_mux;
  logic              en_set, en_clr, pend_clr;

  assign a_grp = bus_addr[ADDR_W-1:2];
  assign a_sub = bus_addr[1:0];

  pio_sync #(.W(N), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_s)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic       hit;
    logic [2:0] port_wr;
    assign hit = (a_grp == GRP_W'(g));
    for (genvar p = 0; p < 3; p++) begin : g_port
      assign port_wr[p] = bus_wr && hit && (a_sub == 2'(p));
    end
    pio_group #(.W(W)) i_group (
      .clk     (clk),
      .rst     (rst),
      .port_wr (port_wr),
      .ctrl_wr (bus_wr && hit && (a_sub == 2'd3)),
      .wdata   (bus_wdata),
      .lat_q   (pin_out[g*GW +: GW]),
      .oe_q    (pin_oe[g*GW +: GW]),
      .mode_q  (mode_q[g])
    );
    assign irq_src[g] = pin_s[g*GW + 2*W + IRQ_BIT];
  end

  assign en_set   = bus_wr && (bus_addr == ADDR_W'(IRQ_EN_ADDR));
  assign en_clr   = bus_rd && (bus_addr == ADDR_W'(IRQ_EN_ADDR));
  assign pend_clr = bus_wr && (bus_addr == ADDR_W'(IRQ_CLR_ADDR));

  pio_irq #(.G(GROUPS)) i_irq (
    .clk      (clk),
    .rst      (rst),
    .en_set   (en_set),
    .en_clr   (en_clr),
    .pend_clr (pend_clr),
    .src      (irq_src),
    .irq      (irq)
  );

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (a_grp == GRP_W'(g)) begin
        if (a_sub == 2'd3) rd_mux = mode_q[g];
        else               rd_mux = pin_s[g*GW + int'(a_sub)*W +: W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (int'(bus_addr) >= GROUPS*4)) |=> (bus_rdata == '0));

endmodule

// File: tb/test_pio_dual_group.sv
module test_pio_dual_group;

  localparam int G = 2;
  localparam int W = 8;
  localparam int N = G * 3 * W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out;
  logic [N-1:0] pin_oe;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model
  logic [7:0]   ctrl_m [G];
  logic [N-1:0] lat_m;
  logic [N-1:0] pins_m;
  logic         en_m;
  logic [G-1:0] pend_m;

  always #4 clk = ~clk;

  pio_dual_group i_pio_dual_group (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_oe();
    logic [N-1:0] o;
    for (int g = 0; g < G; g++) begin
      o[g*24 +: 8]     = {8{~ctrl_m[g][4]}};
      o[g*24+8 +: 8]   = {8{~ctrl_m[g][1]}};
      o[g*24+16 +: 4]  = {4{~ctrl_m[g][0]}};
      o[g*24+20 +: 4]  = {4{~ctrl_m[g][3]}};
    end
    return o;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    int g = int'(a) / 4;
    int p = int'(a) % 4;
    if (g >= G) return 8'h00;
    if (p == 3) return ctrl_m[g];
    return pins_m[g*24 + p*8 +: 8];
  endfunction

  task automatic check_outs(input string req);
    chk({req, " pin_out"}, 64'(pin_out), 64'(lat_m));
    chk({req, " pin_oe"}, 64'(pin_oe), 64'(exp_oe()));
    chk({req, " irq"}, 64'(irq), 64'(|pend_m));
  endtask

  task automatic bwr(input logic [3:0] a, input logic [7:0] d);
    int g = int'(a) / 4;
    int p = int'(a) % 4;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (g < G) begin
      if (p == 3) begin
        if (d[7]) begin
          ctrl_m[g] = d;
          lat_m[g*24 +: 24] = '0;
        end
      end else begin
        lat_m[g*24 + p*8 +: 8] = d;
      end
    end
    if (a == 4'hB) en_m = 1'b1;
    if (a == 4'hF) pend_m = '0;
  endtask

  task automatic brd(input logic [3:0] a, input string req);
    logic [7:0] e;
    e = exp_rd(a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, 64'(bus_rdata), 64'(e));
    if (a == 4'hB) en_m = 1'b0;
  endtask

  task automatic setpins(input logic [N-1:0] v);
    for (int g = 0; g < G; g++)
      if (en_m && !pins_m[g*24+19] && v[g*24+19]) pend_m[g] = 1'b1;
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
    pins_m = v;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    void'($urandom(32'h1F2E3D4C));
    for (int g = 0; g < G; g++) ctrl_m[g] = 8'h80;
    lat_m = '0; pins_m = '0; en_m = 1'b0; pend_m = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 pin_oe", 64'(pin_oe), {16'h0, {N{1'b1}}});
    chk("R1 pin_out", 64'(pin_out), 64'h0);
    chk("R1 irq", 64'(irq), 64'h0);
    brd(4'h3, "R1 mode0 readback");
    brd(4'h7, "R1 mode1 readback");

    // R2 port writes
    bwr(4'h0, 8'hA5); bwr(4'h1, 8'h3C); bwr(4'h2, 8'hF0);
    bwr(4'h4, 8'h81); bwr(4'h5, 8'h7E); bwr(4'h6, 8'h0F);
    check_outs("R2");

    // R3/R4 mode set all inputs on group 0, group 1 unchanged
    bwr(4'h3, 8'h9B);
    check_outs("R3 R4 group0 all inputs");
    brd(4'h3, "R3 mode0 stored");
    // R3 only C upper half input on group 1
    bwr(4'h7, 8'h88);
    check_outs("R3 R4 group1 C high input");
    bwr(4'h7, 8'h81);
    check_outs("R3 group1 C low input");
    // R2 latch loads while input
    bwr(4'h0, 8'h5A);
    check_outs("R2 latch while input");

    // R5 plain control write ignored
    bwr(4'h3, 8'h1B);
    bwr(4'h7, 8'h00);
    check_outs("R5 plain ctrl");
    brd(4'h3, "R5 mode0 unchanged");
    brd(4'h7, "R5 mode1 unchanged");

    // R6 pin readback
    setpins(48'hDEAD_BEEF_1234);
    for (int a = 0; a < 8; a++) brd(4'(a), "R6 readback");

    // R7 unmapped
    for (int a = 8; a < 16; a++) brd(4'(a), "R7 unmapped read");

    // R8/R10/R11 interrupt
    setpins('0);
    bwr(4'hB, 8'h00);
    setpins(48'h1 << 19);
    check_outs("R8 R10 rise group0");
    setpins('0);
    check_outs("R10 sticky after fall");
    bwr(4'hF, 8'h55);
    check_outs("R11 clear");
    setpins(48'h1 << 18);
    check_outs("R10 other line");
    brd(4'hB, "R9 disable read");
    setpins(48'h1 << 43);
    check_outs("R9 disabled no pend");
    setpins('0);
    bwr(4'hB, 8'hFF);
    setpins(48'h1 << 43);
    check_outs("R10 rise group1");
    brd(4'hB, "R9 disable keeps pend");
    check_outs("R9 pending held");
    bwr(4'hF, 8'h00);
    check_outs("R11 clear group1");

    // random traffic
    for (int i = 0; i < 500; i++) begin
      int op = int'($urandom % 6);
      logic [3:0] a = 4'($urandom);
      if (op < 2) begin
        bwr(a, 8'($urandom));
        check_outs("R2 R3 R4 R5 R8 R11 random write");
      end else if (op < 4) begin
        brd(a, "R6 R7 random read");
      end else begin
        v = pins_m ^ ({$urandom, $urandom} & {16'h0, 32'h0101_0101})
                   ^ ({$urandom} % 2 == 0 ? (48'h1 << 19) : (48'h1 << 43));
        setpins(v);
        check_outs("R10 random pins");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule